// File: doc/BRIEF.md
# Synchronous DRAM Refresh Scheduler with Self-Refresh Control

This block paces periodic auto-refresh for a synchronous DRAM and steers the memory into and out of self-refresh on behalf of a memory bus controller. It holds its own control fields: a refresh-enable bit, a self-mode bit and a row-active-time field, along with a refresh interval constant and a refresh interval counter. The counter advances on a prescaler tick. When it reaches the constant, a refresh request is raised. The request waits while a bus cycle is in flight or while the bus is lent to another master, and it is then issued as a one-cycle command strobe.

Setting both control bits moves the memory into self-refresh. The command strobe fires with clock enable dropping in the same cycle. Clock enable stays low, commands stay inhibited, and the bus is not lent out until software clears the self-mode bit. A recovery window then follows, during which no command may be issued. A manual reset only drops a waiting request. Power-on reset returns every field to its initial value and so ends self-refresh.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: After power-on reset, clockEn is 1, refreshCmd is 0, cmdInhibit is 0, overrunFlag is 0 and the counter reads 0.
- R2: On a tick with refresh enabled and no self-refresh, the counter advances by one. When the advanced value equals the constant, the counter clears to 0 and a request is raised. Without a tick the counter holds. With the bus free, refreshCmd is high for exactly one cycle, with clockEn high, on the second clock edge after the matching tick.
- R3: A waiting request is not issued while busBusy is 1. It is issued on the first edge at which busBusy is seen as 0.
- R4: A waiting request is not issued while busLent is 1. It is issued once busLent returns to 0.
- R5: At most one request waits. A match while one is waiting yields a single refresh and sets overrunFlag. Writing overrunClr clears overrunFlag.
- R6: When refresh-enable and self-mode are both 1 and the bus is free, the next edge drives refreshCmd high with clockEn low in the same cycle. clockEn then stays low and cmdInhibit stays high.
- R7: Clearing self-mode raises clockEn. cmdInhibit stays high for exactly rowActive+1 cycles and then falls.
- R8: During self-refresh the counter ignores ticks. After exit with refresh enabled, periodic refresh resumes.
- R9: busGrant equals extBusReq, except while in self-refresh, when it is 0.
- R10: Manual reset keeps self-refresh and clears only a waiting request. Power-on reset ends self-refresh.
- R11: Loading the counter with the constant minus one makes the very next tick produce a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, asynchronous, active low |
| rstManN | input | 1 | Manual reset, synchronous, active low |
| ctlWr | input | 1 | Write strobe for the control fields |
| ctlRefEn | input | 1 | Refresh-enable value to write |
| ctlSelfMode | input | 1 | Self-mode value to write |
| ctlRowActive | input | RAS_W | Row-active-time value to write |
| constWr | input | 1 | Write strobe for the refresh constant |
| constData | input | CNT_W | Refresh constant value |
| cntWr | input | 1 | Write strobe for the refresh counter (wins over a tick) |
| cntWrData | input | CNT_W | Refresh counter value |
| overrunClr | input | 1 | Write-one-to-clear for overrunFlag |
| tick | input | 1 | Prescaler tick |
| busBusy | input | 1 | A bus cycle is in progress |
| busLent | input | 1 | Bus is granted to an external master |
| extBusReq | input | 1 | External master requests the bus |
| refreshCmd | output | 1 | Refresh command strobe |
| clockEn | output | 1 | Memory clock enable |
| cmdInhibit | output | 1 | No command may be issued |
| busGrant | output | 1 | Gated bus grant |
| overrunFlag | output | 1 | Sticky flag for a lost refresh request |
| cntVal | output | CNT_W | Current counter value |

## Verification
Some rules are checked by assertions on every cycle. A refresh strobe never follows a cycle in which the bus was busy or lent. The strobe is one cycle wide. clockEn only falls together with a strobe. The grant is never given while clockEn is low. The overrun flag only rises on a tick. The bench scenarios are needed for the rest: the exact count of refreshes for each constant, the recovery window length for each row-active setting, the single refresh that survives a lost request, and the different effects of the two resets.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SELF  = 2'd1,
    ST_RECOV = 2'd2
  } refState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRun;   // counter may advance on tick
    logic pendClr;  // waiting request consumed this cycle
  } dpCtl_t;
endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int RAS_W = 2
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             rstManN,
  input  logic             ctlWr,
  input  logic             ctlRefEn,
  input  logic             ctlSelfMode,
  input  logic [RAS_W-1:0] ctlRowActive,
  input  logic             constWr,
  input  logic [CNT_W-1:0] constData,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             overrunClr,
  input  logic             tick,
  input  dpCtl_t           ctl,
  output logic             refEn,
  output logic             selfMode,
  output logic [RAS_W-1:0] rowActive,
  output logic             pendReq,
  output logic             overrunFlag,
  output logic [CNT_W-1:0] cntVal
);
  logic [CNT_W-1:0] constReg;
  logic [CNT_W-1:0] cntNext;
  logic             match;

  assign cntNext = CNT_W'(cntVal + 1'b1);
  assign match   = !cntWr && tick && ctl.cntRun && (cntNext == constReg);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      refEn     <= 1'b0;
      selfMode  <= 1'b0;
      rowActive <= '0;
      constReg  <= '1;
    end else begin
      if (ctlWr) begin
        refEn     <= ctlRefEn;
        selfMode  <= ctlSelfMode;
        rowActive <= ctlRowActive;
      end
      if (constWr) constReg <= constData;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      cntVal <= '0;
    end else if (cntWr) begin
      cntVal <= cntWrData;
    end else if (tick && ctl.cntRun) begin
      cntVal <= match ? '0 : cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      pendReq <= 1'b0;
    end else if (!rstManN) begin
      pendReq <= 1'b0;
    end else if (match) begin
      pendReq <= 1'b1;
    end else if (ctl.pendClr) begin
      pendReq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      overrunFlag <= 1'b0;
    end else if (match && pendReq && !ctl.pendClr && rstManN) begin
      overrunFlag <= 1'b1;
    end else if (overrunClr) begin
      overrunFlag <= 1'b0;
    end
  end

  // R5: the overrun flag can only be set by a counter match, which needs a tick
  a_r5_overrun_on_tick: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(overrunFlag) |-> $past(tick));

  // R8: counter holds while the control forbids counting and no write occurs
  a_r8_counter_frozen: assert property (@(posedge clk) disable iff (!rstPorN)
    (!ctl.cntRun && !cntWr) |=> $stable(cntVal));
endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import refresh_pkg::*;
#(
  parameter int RAS_W = 2
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             refEn,
  input  logic             selfMode,
  input  logic [RAS_W-1:0] rowActive,
  input  logic             pendReq,
  input  logic             busBusy,
  input  logic             busLent,
  input  logic             extBusReq,
  output dpCtl_t           ctl,
  output logic             refreshCmd,
  output logic             clockEn,
  output logic             cmdInhibit,
  output logic             busGrant
);
  refState_t        state;
  logic [RAS_W-1:0] recCnt;
  logic             busFree;
  logic             goSelf;
  logic             goRefresh;

  assign busFree   = !busBusy && !busLent;
  assign goSelf    = (state == ST_IDLE) && busFree && refEn && selfMode;
  assign goRefresh = (state == ST_IDLE) && busFree && refEn && pendReq && !selfMode;

  assign ctl.cntRun  = refEn && (state != ST_SELF);
  assign ctl.pendClr = goSelf || goRefresh;

  assign cmdInhibit = (state != ST_IDLE);
  assign busGrant   = extBusReq && (state != ST_SELF);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      state      <= ST_IDLE;
      refreshCmd <= 1'b0;
      clockEn    <= 1'b1;
      recCnt     <= '0;
    end else begin
      refreshCmd <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (goSelf) begin
            state      <= ST_SELF;
            refreshCmd <= 1'b1;
            clockEn    <= 1'b0;
          end else if (goRefresh) begin
            refreshCmd <= 1'b1;
          end
        end
        ST_SELF: begin
          if (!selfMode) begin
            state   <= ST_RECOV;
            clockEn <= 1'b1;
            recCnt  <= rowActive;
          end
        end
        ST_RECOV: begin
          if (recCnt == '0) state <= ST_IDLE;
          else              recCnt <= recCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the refresh strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstPorN)
    refreshCmd |=> !refreshCmd);

  // R3: no strobe decided while a bus cycle was running
  a_r3_not_while_busy: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(refreshCmd) |-> !$past(busBusy));

  // R4: no strobe decided while the bus was lent out
  a_r4_not_while_lent: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(refreshCmd) |-> !$past(busLent));

  // R6: clock enable only falls together with a refresh strobe
  a_r6_entry_with_cmd: assert property (@(posedge clk) disable iff (!rstPorN)
    $fell(clockEn) |-> refreshCmd);

  // R7: clock enable rises into the recovery window
  a_r7_exit_inhibited: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(clockEn) |-> cmdInhibit);

  // R9: no grant while the memory clock is stopped
  a_r9_no_grant_in_self: assert property (@(posedge clk) disable iff (!rstPorN)
    !clockEn |-> !busGrant);
endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int RAS_W = 2
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             rstManN,
  input  logic             ctlWr,
  input  logic             ctlRefEn,
  input  logic             ctlSelfMode,
  input  logic [RAS_W-1:0] ctlRowActive,
  input  logic             constWr,
  input  logic [CNT_W-1:0] constData,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             overrunClr,
  input  logic             tick,
  input  logic             busBusy,
  input  logic             busLent,
  input  logic             extBusReq,
  output logic             refreshCmd,
  output logic             clockEn,
  output logic             cmdInhibit,
  output logic             busGrant,
  output logic             overrunFlag,
  output logic [CNT_W-1:0] cntVal
);
  dpCtl_t           ctl;
  logic             refEn;
  logic             selfMode;
  logic [RAS_W-1:0] rowActive;
  logic             pendReq;

  refresh_datapath #(.CNT_W(CNT_W), .RAS_W(RAS_W)) dp_i (
    .clk(clk), .rstPorN(rstPorN), .rstManN(rstManN),
    .ctlWr(ctlWr), .ctlRefEn(ctlRefEn), .ctlSelfMode(ctlSelfMode),
    .ctlRowActive(ctlRowActive), .constWr(constWr), .constData(constData),
    .cntWr(cntWr), .cntWrData(cntWrData), .overrunClr(overrunClr),
    .tick(tick), .ctl(ctl), .refEn(refEn), .selfMode(selfMode),
    .rowActive(rowActive), .pendReq(pendReq), .overrunFlag(overrunFlag),
    .cntVal(cntVal)
  );

  refresh_control #(.RAS_W(RAS_W)) ctrl_i (
    .clk(clk), .rstPorN(rstPorN), .refEn(refEn), .selfMode(selfMode),
    .rowActive(rowActive), .pendReq(pendReq), .busBusy(busBusy),
    .busLent(busLent), .extBusReq(extBusReq), .ctl(ctl),
    .refreshCmd(refreshCmd), .clockEn(clockEn), .cmdInhibit(cmdInhibit),
    .busGrant(busGrant)
  );
endmodule

// File: tb/sdram_refresh_ctrl_tb_top.sv
module sdram_refresh_ctrl_tb_top;
  localparam int CNT_W = 8;
  localparam int RAS_W = 2;

  logic clk = 1'b0;
  logic rstPorN = 1'b0, rstManN = 1'b1;
  logic ctlWr = 1'b0, ctlRefEn = 1'b0, ctlSelfMode = 1'b0;
  logic [RAS_W-1:0] ctlRowActive = '0;
  logic constWr = 1'b0;
  logic [CNT_W-1:0] constData = '0;
  logic cntWr = 1'b0;
  logic [CNT_W-1:0] cntWrData = '0;
  logic overrunClr = 1'b0, tick = 1'b0;
  logic busBusy = 1'b0, busLent = 1'b0, extBusReq = 1'b0;
  logic refreshCmd, clockEn, cmdInhibit, busGrant, overrunFlag;
  logic [CNT_W-1:0] cntVal;

  int checks = 0, errors = 0, refCount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_refresh_ctrl #(.CNT_W(CNT_W), .RAS_W(RAS_W)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (refreshCmd) refCount++;
    end
  endtask

  task automatic wrCtl(bit en, bit sm, int ras);
    ctlWr = 1; ctlRefEn = en; ctlSelfMode = sm; ctlRowActive = RAS_W'(ras);
    cyc(1); ctlWr = 0;
  endtask

  task automatic wrConst(int v);
    constWr = 1; constData = CNT_W'(v); cyc(1); constWr = 0;
  endtask

  task automatic wrCnt(int v);
    cntWr = 1; cntWrData = CNT_W'(v); cyc(1); cntWr = 0;
  endtask

  task automatic tickOnce();
    tick = 1; cyc(1); tick = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc0;
    int c0;
    cyc(3);
    // R1 reset state
    chk("R1 clockEn", clockEn, 1);
    chk("R1 refreshCmd", refreshCmd, 0);
    chk("R1 cmdInhibit", cmdInhibit, 0);
    chk("R1 overrun", overrunFlag, 0);
    chk("R1 counter", cntVal, 0);
    rstPorN = 1;
    cyc(2);
    wrCtl(1, 0, 2);

    // R11 / R2 latency sweep over constants
    for (int k = 2; k <= 9; k++) begin
      wrConst(k);
      wrCnt(k - 1);
      tickOnce();
      chk("R11 no strobe yet", refreshCmd, 0);
      chk("R2 counter cleared", cntVal, 0);
      cyc(1);
      chk("R11 strobe", refreshCmd, 1);
      chk("R2 clockEn high", clockEn, 1);
      cyc(1);
      chk("R2 one cycle", refreshCmd, 0);
    end

    // R2 interval sweep
    for (int k = 2; k <= 6; k++) begin
      wrConst(k);
      wrCnt(0);
      rc0 = refCount;
      for (int i = 0; i < 3 * k; i++) begin
        tick = 1; cyc(1); tick = 0; cyc(1);
      end
      cyc(3);
      chk("R2 refresh count", refCount - rc0, 3);
      chk("R2 counter end", cntVal, 0);
    end
    wrCnt(1);
    cyc(10);
    chk("R2 hold without tick", cntVal, 1);

    // R3 busy holds off
    wrConst(5);
    busBusy = 1;
    wrCnt(4);
    tickOnce();
    rc0 = refCount;
    cyc(6);
    chk("R3 held", refCount - rc0, 0);
    busBusy = 0;
    cyc(1);
    chk("R3 issued", refreshCmd, 1);

    // R4 bus lent holds off
    busLent = 1;
    wrCnt(4);
    tickOnce();
    rc0 = refCount;
    cyc(6);
    chk("R4 held", refCount - rc0, 0);
    busLent = 0;
    cyc(1);
    chk("R4 issued", refreshCmd, 1);
    cyc(2);

    // R5 single waiting request, overrun
    busBusy = 1;
    wrCnt(4);
    tickOnce();
    chk("R5 no overrun", overrunFlag, 0);
    wrCnt(4);
    tickOnce();
    chk("R5 overrun set", overrunFlag, 1);
    rc0 = refCount;
    busBusy = 0;
    cyc(6);
    chk("R5 single refresh", refCount - rc0, 1);
    overrunClr = 1; cyc(1); overrunClr = 0;
    chk("R5 overrun cleared", overrunFlag, 0);

    // R10 manual reset drops waiting request
    busBusy = 1;
    wrCnt(4);
    tickOnce();
    rstManN = 0; cyc(1); rstManN = 1;
    rc0 = refCount;
    busBusy = 0;
    cyc(5);
    chk("R10 request dropped", refCount - rc0, 0);

    // R6 self-refresh entry
    extBusReq = 1;
    rc0 = refCount;
    wrCtl(1, 1, 2);
    cyc(1);
    chk("R6 entry strobe", refreshCmd, 1);
    chk("R6 clockEn low", clockEn, 0);
    chk("R6 inhibit", cmdInhibit, 1);
    cyc(1);
    chk("R6 strobe ends", refreshCmd, 0);
    chk("R6 clockEn stays low", clockEn, 0);
    chk("R9 grant withheld", busGrant, 0);
    // R8 counter frozen in self-refresh
    c0 = cntVal;
    rc0 = refCount;
    for (int i = 0; i < 10; i++) begin
      tick = 1; cyc(1);
    end
    tick = 0;
    chk("R8 counter frozen", cntVal, c0);
    chk("R8 no refresh in self", refCount - rc0, 0);
    // R10 manual reset keeps self-refresh
    rstManN = 0; cyc(2); rstManN = 1; cyc(1);
    chk("R10 self survives", clockEn, 0);

    // R7 recovery window sweep
    for (int r = 0; r < (1 << RAS_W); r++) begin
      wrCtl(1, 1, r);
      cyc(3);
      chk("R6 in self", clockEn, 0);
      chk("R9 no grant", busGrant, 0);
      wrCtl(1, 0, r);
      cyc(1);
      chk("R7 clockEn up", clockEn, 1);
      chk("R7 inhibit start", cmdInhibit, 1);
      chk("R9 grant after exit", busGrant, 1);
      for (int j = 0; j < r; j++) begin
        cyc(1);
        chk("R7 inhibit held", cmdInhibit, 1);
      end
      cyc(1);
      chk("R7 inhibit ends", cmdInhibit, 0);
    end
    extBusReq = 0;

    // R8 periodic refresh resumes
    wrConst(3);
    wrCnt(2);
    tickOnce();
    cyc(1);
    chk("R8 refresh resumes", refreshCmd, 1);

    // R10 power-on reset ends self-refresh
    wrCtl(1, 1, 1);
    cyc(2);
    chk("R10 in self", clockEn, 0);
    rstPorN = 0;
    #1;
    chk("R10 por clockEn", clockEn, 1);
    chk("R10 por inhibit", cmdInhibit, 0);
    cyc(2);
    rstPorN = 1;
    cyc(3);
    chk("R10 stays out", clockEn, 1);
    chk("R1 overrun after por", overrunFlag, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule